// File: doc/BRIEF.md
# Cache-Block Access Permission Prober

This block decides whether a cache-block operation may touch the block that holds a given effective address. It clears the low address bits to reach the start of the block. It then asks an external translation and permission checker about the whole block, one query at a time, through a valid/ready query channel and a separate response strobe. A completion pulse reports the outcome.

There are two kinds of operation. A maintenance operation (clean, flush or invalidate) is granted if the block may be read, fetched or written. The prober tries these three in that fixed order and stops at the first grant. Only the last query, the write query, is allowed to fault in the checker. If all three are refused, the outcome is a store-class fault. This is a guest-page fault when the request was made with virtualisation enabled, and a plain store page fault otherwise. The aligned address is returned as the trap value.

A zero operation uses its own block size. It asks only for write permission. When that is granted, it issues a block-wide zero-write command.

Top module: `cbp_prober`

## Requirements
- R1: Every query carries the request address with its low log2(size) bits cleared, and the block size in bytes on `q_len`. The size is `MGMT_BLK` (default 64) when `req_zero`=0 and `ZERO_BLK` (default 64) when `req_zero`=1.
- R2: A maintenance request queries `q_type` 0 (load), then 1 (fetch), then 2 (store), moving on only after a refusal (`r_grant`=0).
- R3: The first granted query ends the operation with `done_ok`=1, and no further query is issued.
- R4: `q_fault_ok` is 1 exactly when `q_type` is 2 (store).
- R5: When the final store query is refused, `done_ok`=0. `done_fault_guest` equals the `req_virt` value captured with the request: 1 selects a store guest-page fault, 0 a store page fault.
- R6: `done_tval` equals the aligned request address in the completion cycle.
- R7: A zero request issues a single store query. On a grant, `zw_valid` pulses in the completion cycle with `zw_addr` set to the aligned address and `zw_len`=`ZERO_BLK`. On a refusal there is no zero-write and a fault is reported as in R5.
- R8: Only one query is in flight at a time. While `q_valid`=1 and `q_ready`=0, the query holds stable. `q_valid` stays 0 from acceptance until the response.
- R9: `r_valid` is ignored unless a query was accepted in an earlier cycle and has not yet been answered.
- R10: After reset, `req_ready`=1, `q_valid`=0 and `done_valid`=0. `req_ready` is 1 only while idle, so requests made while busy are not taken.
- R11: `done_valid` is a single-cycle pulse, and `req_ready` returns in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Prober idle, request taken |
| req_zero | input | 1 | 1 = zero operation, 0 = maintenance |
| req_virt | input | 1 | Virtualisation enabled for this request |
| req_addr | input | AW | Effective address |
| q_valid | output | 1 | Permission query valid |
| q_ready | input | 1 | Checker accepts query |
| q_type | output | 2 | 0 load, 1 fetch, 2 store |
| q_fault_ok | output | 1 | Query may raise a fault |
| q_addr | output | AW | Aligned block address |
| q_len | output | LEN_W | Block length in bytes |
| r_valid | input | 1 | Query response strobe |
| r_grant | input | 1 | Access permitted |
| done_valid | output | 1 | Completion pulse |
| done_ok | output | 1 | Operation permitted |
| done_fault_guest | output | 1 | Fault is a guest-page fault |
| done_tval | output | AW | Aligned address (trap value) |
| zw_valid | output | 1 | Block zero-write command |
| zw_addr | output | AW | Zero-write block address |
| zw_len | output | LEN_W | Zero-write length in bytes |

## Verification
Two things can share one cycle: a response strobe, and a query being offered and accepted. A strobe that arrives in the acceptance cycle, or while nothing is in flight, must not advance the sequence.

The bench drives spurious `r_valid` pulses with random `r_grant` on every cycle in which no accepted query is waiting. This includes the cycle of the query handshake itself. The bench judges the result by comparing the whole sequence of query types, and the final outcome, against a sequence computed from the per-step grant plan. An early transition shows up as a missing or reordered query, or as a wrong `done_ok`.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_FETCH = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_FETCH,
    ST_STORE,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/cbp_align.sv
module cbp_align #(
  parameter int AW  = 32,
  parameter int BLK = 64
) (
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LOW_MASK = AW'(BLK - 1);

  assign addr_o = addr_i & ~LOW_MASK;
endmodule

// File: rtl/cbp_seq.sv
module cbp_seq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_zero,
  input  logic          req_virt,
  input  logic [AW-1:0] req_aligned,
  output logic          req_ready,
  output logic          q_valid,
  input  logic          q_ready,
  output logic [1:0]    q_type,
  output logic          q_fault_ok,
  output logic [AW-1:0] blk_addr,
  input  logic          r_valid,
  input  logic          r_grant,
  output logic          op_zero,
  output logic          done_valid,
  output logic          done_ok,
  output logic          done_fault_guest,
  output logic          zw_valid
);
  import cbp_pkg::*;

  seq_st_e       state_q, state_d;
  logic          issued_q, issued_d;
  logic          ok_q, ok_d;
  logic          cap_en;
  logic          zero_q, virt_q;
  logic [AW-1:0] addr_q;
  logic          in_query;

  assign in_query = (state_q == ST_LOAD) || (state_q == ST_FETCH) ||
                    (state_q == ST_STORE);

  always_comb begin
    state_d  = state_q;
    issued_d = issued_q;
    ok_d     = ok_q;
    cap_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_en   = 1'b1;
          issued_d = 1'b0;
          state_d  = req_zero ? ST_STORE : ST_LOAD;
        end
      end
      ST_LOAD, ST_FETCH, ST_STORE: begin
        if (!issued_q && q_ready) begin
          issued_d = 1'b1;
        end
        if (issued_q && r_valid) begin
          issued_d = 1'b0;
          if (r_grant) begin
            ok_d    = 1'b1;
            state_d = ST_DONE;
          end else if (state_q == ST_STORE) begin
            ok_d    = 1'b0;
            state_d = ST_DONE;
          end else begin
            state_d = (state_q == ST_LOAD) ? ST_FETCH : ST_STORE;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      issued_q <= issued_d;
      ok_q     <= ok_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      zero_q <= 1'b0;
      virt_q <= 1'b0;
    end else if (cap_en) begin
      addr_q <= req_aligned;
      zero_q <= req_zero;
      virt_q <= req_virt;
    end
  end

  always_comb begin
    case (state_q)
      ST_FETCH: q_type = ACC_FETCH;
      ST_STORE: q_type = ACC_STORE;
      default:  q_type = ACC_LOAD;
    endcase
  end

  assign req_ready        = (state_q == ST_IDLE);
  assign q_valid          = in_query && !issued_q;
  assign q_fault_ok       = (state_q == ST_STORE);
  assign blk_addr         = addr_q;
  assign op_zero          = zero_q;
  assign done_valid       = (state_q == ST_DONE);
  assign done_ok          = done_valid && ok_q;
  assign done_fault_guest = done_valid && !ok_q && virt_q;
  assign zw_valid         = done_valid && ok_q && zero_q;
endmodule

// File: rtl/cbp_prober.sv
module cbp_prober #(
  parameter int AW       = 32,
  parameter int LEN_W    = 16,
  parameter int MGMT_BLK = 64,
  parameter int ZERO_BLK = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_zero,
  input  logic             req_virt,
  input  logic [AW-1:0]    req_addr,
  output logic             q_valid,
  input  logic             q_ready,
  output logic [1:0]       q_type,
  output logic             q_fault_ok,
  output logic [AW-1:0]    q_addr,
  output logic [LEN_W-1:0] q_len,
  input  logic             r_valid,
  input  logic             r_grant,
  output logic             done_valid,
  output logic             done_ok,
  output logic             done_fault_guest,
  output logic [AW-1:0]    done_tval,
  output logic             zw_valid,
  output logic [AW-1:0]    zw_addr,
  output logic [LEN_W-1:0] zw_len
);
  localparam logic [LEN_W-1:0] MGMT_LEN = LEN_W'(MGMT_BLK);
  localparam logic [LEN_W-1:0] ZERO_LEN = LEN_W'(ZERO_BLK);

  logic          rst_meta, rst_sync_n;
  logic [AW-1:0] mgmt_aligned, zero_aligned, sel_aligned;
  logic [AW-1:0] blk_addr;
  logic          op_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  cbp_align #(.AW(AW), .BLK(MGMT_BLK)) i_align_mgmt (
    .addr_i(req_addr), .addr_o(mgmt_aligned)
  );
  cbp_align #(.AW(AW), .BLK(ZERO_BLK)) i_align_zero (
    .addr_i(req_addr), .addr_o(zero_aligned)
  );

  assign sel_aligned = req_zero ? zero_aligned : mgmt_aligned;

  cbp_seq #(.AW(AW)) i_seq (
    .clk              (clk),
    .rst_n            (rst_sync_n),
    .req_valid        (req_valid),
    .req_zero         (req_zero),
    .req_virt         (req_virt),
    .req_aligned      (sel_aligned),
    .req_ready        (req_ready),
    .q_valid          (q_valid),
    .q_ready          (q_ready),
    .q_type           (q_type),
    .q_fault_ok       (q_fault_ok),
    .blk_addr         (blk_addr),
    .r_valid          (r_valid),
    .r_grant          (r_grant),
    .op_zero          (op_zero),
    .done_valid       (done_valid),
    .done_ok          (done_ok),
    .done_fault_guest (done_fault_guest),
    .zw_valid         (zw_valid)
  );

  assign q_addr    = blk_addr;
  assign q_len     = op_zero ? ZERO_LEN : MGMT_LEN;
  assign done_tval = blk_addr;
  assign zw_addr   = blk_addr;
  assign zw_len    = ZERO_LEN;
endmodule

// File: rtl/cbp_prober_chk.sv
module cbp_prober_chk #(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             q_valid,
  input logic             q_ready,
  input logic [1:0]       q_type,
  input logic             q_fault_ok,
  input logic [AW-1:0]    q_addr,
  input logic [LEN_W-1:0] q_len,
  input logic             done_valid,
  input logic             done_ok,
  input logic             done_fault_guest,
  input logic             zw_valid
);
  a_r8_query_hold: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && !q_ready |=> q_valid && $stable(q_addr) && $stable(q_type));

  a_r8_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && q_ready |=> !q_valid);

  a_r4_fault_on_store: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> (q_fault_ok == (q_type == 2'd2)));

  a_r1_query_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> ((q_addr & AW'(q_len - 1'b1)) == '0));

  a_r10_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && req_ready);

  a_r7_zero_write_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
    zw_valid |-> done_valid && done_ok);

  a_r5_guest_only_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    done_fault_guest |-> done_valid && !done_ok);
endmodule

bind cbp_prober cbp_prober_chk #(.AW(AW), .LEN_W(LEN_W)) i_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_valid        (req_valid),
  .req_ready        (req_ready),
  .q_valid          (q_valid),
  .q_ready          (q_ready),
  .q_type           (q_type),
  .q_fault_ok       (q_fault_ok),
  .q_addr           (q_addr),
  .q_len            (q_len),
  .done_valid       (done_valid),
  .done_ok          (done_ok),
  .done_fault_guest (done_fault_guest),
  .zw_valid         (zw_valid)
);

// File: tb/test_cbp_prober.sv
`timescale 1ns/1ps
module test_cbp_prober;
  localparam int AW = 32, LEN_W = 16, MGMT = 64, ZBLK = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_zero = 0, req_virt = 0;
  logic [AW-1:0] req_addr = '0;
  logic q_ready = 0, r_valid = 0, r_grant = 0;
  logic req_ready, q_valid, q_fault_ok, done_valid, done_ok, done_fault_guest, zw_valid;
  logic [1:0] q_type;
  logic [AW-1:0] q_addr, done_tval, zw_addr;
  logic [LEN_W-1:0] q_len, zw_len;

  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  cbp_prober #(.AW(AW), .LEN_W(LEN_W), .MGMT_BLK(MGMT), .ZERO_BLK(ZBLK)) i_cbp_prober (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_zero(req_zero), .req_virt(req_virt), .req_addr(req_addr),
    .q_valid(q_valid), .q_ready(q_ready), .q_type(q_type), .q_fault_ok(q_fault_ok),
    .q_addr(q_addr), .q_len(q_len), .r_valid(r_valid), .r_grant(r_grant),
    .done_valid(done_valid), .done_ok(done_ok), .done_fault_guest(done_fault_guest),
    .done_tval(done_tval), .zw_valid(zw_valid), .zw_addr(zw_addr), .zw_len(zw_len)
  );

  task automatic check(input bit cond, input string req, input longint act, input longint exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_align(input logic [AW-1:0] a, input bit zero);
    int sz = zero ? ZBLK : MGMT;
    return a & ~(AW'(sz - 1));
  endfunction

  function automatic int exp_nq(input bit zero, input bit [2:0] g);
    if (zero) return 1;
    if (g[0]) return 1;
    if (g[1]) return 2;
    return 3;
  endfunction

  task automatic run_op(input bit zero, input bit virt, input logic [AW-1:0] addr,
                        input bit [2:0] g);
    logic [AW-1:0] al = exp_align(addr, zero);
    int nq = exp_nq(zero, g);
    bit ok = zero ? g[2] : (|g);
    int qi = 0, lat = 0, cyc = 0;
    bit outstanding = 0, done_seen = 0, hold = 0;
    logic [AW-1:0] h_addr = '0;
    logic [1:0] h_type = '0, cur = '0;
    @(negedge clk);
    while (!req_ready && cyc < 50) begin @(negedge clk); cyc++; end
    req_valid = 1; req_zero = zero; req_virt = virt; req_addr = addr;
    @(negedge clk);
    req_valid = 0; req_addr = $urandom; req_virt = $urandom; req_zero = $urandom;
    check(!req_ready, "R10 busy after take", req_ready, 0);
    cyc = 0;
    while (!done_seen && cyc < 300) begin
      if (hold) check(q_valid && q_addr == h_addr && q_type == h_type,
                      "R8 query held", q_addr, h_addr);
      if (outstanding && q_valid) check(0, "R8 one in flight", q_valid, 0);
      if (zw_valid && !done_valid) check(0, "R7 stray zero-write", zw_valid, 0);
      if (done_valid) begin
        done_seen = 1; q_ready = 0; r_valid = 0; hold = 0;
        check(qi == nq, "R3 query count", qi, nq);
        check(done_ok == ok, "R3/R5 done_ok", done_ok, ok);
        check(done_fault_guest == (!ok && virt), "R5 guest fault", done_fault_guest, !ok && virt);
        check(done_tval == al, "R6 trap value", done_tval, al);
        check(zw_valid == (zero && ok), "R7 zero-write", zw_valid, zero && ok);
        if (zero && ok) check(zw_addr == al && zw_len == ZBLK, "R7 zero-write block", zw_addr, al);
      end else begin
        r_valid = 0;
        q_ready = $urandom % 2;
        if (outstanding) begin
          if (lat == 0) begin
            r_valid = 1; r_grant = g[cur]; outstanding = 0;
          end else lat--;
        end else begin
          r_valid = ($urandom % 3 == 0); r_grant = $urandom;   // spurious, R9
          if (q_valid && q_ready) begin
            int et = zero ? 2 : qi;
            check(qi < nq && q_type == 2'(et), "R2 query order", q_type, et);
            check(q_addr == al, "R1 aligned address", q_addr, al);
            check(q_len == (zero ? ZBLK : MGMT), "R1 block length", q_len, zero ? ZBLK : MGMT);
            check(q_fault_ok == (q_type == 2'd2), "R4 fault only on store", q_fault_ok, q_type == 2'd2);
            cur = q_type; outstanding = 1; lat = $urandom % 3; qi++;
          end
        end
        hold = q_valid && !q_ready;
        h_addr = q_addr; h_type = q_type;
      end
      @(negedge clk); cyc++;
    end
    r_valid = 0; q_ready = 0;
    check(done_seen, "R3 completion reached", done_seen, 1);
    check(!done_valid && req_ready, "R11 single pulse then ready", done_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check(req_ready && !q_valid && !done_valid, "R10 reset state", {req_ready, q_valid, done_valid}, 3'b100);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(req_ready && !q_valid && !done_valid, "R10 idle after reset", {req_ready, q_valid, done_valid}, 3'b100);
    run_op(0, 0, 32'h1234_567F, 3'b001);
    run_op(0, 1, 32'h0000_0041, 3'b010);
    run_op(0, 0, 32'h8000_003F, 3'b100);
    run_op(0, 0, 32'hFFFF_FFFF, 3'b000);
    run_op(0, 1, 32'hFFFF_FFFF, 3'b000);
    run_op(0, 0, 32'h0000_0000, 3'b111);
    run_op(1, 0, 32'hABCD_EFFF, 3'b100);
    run_op(1, 1, 32'h0000_00C0, 3'b011);
    run_op(1, 0, 32'h0000_007F, 3'b000);
    for (int i = 0; i < 300; i++) run_op($urandom, $urandom, $urandom, 3'($urandom));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule